// File: doc/BRIEF.md
# Three-Phase Staircase Level Sequencer

This block produces the level commands for the three legs of a three-level inverter that runs fundamental-frequency staircase modulation. Each leg sits at one of three levels: low, mid or high. A programmable step timer splits one output period into twelve equal steps. On every step the sequencer moves to the next entry of a fixed twelve-entry ring of leg-level triples.

Consecutive triples in the ring differ in one leg only, and that leg moves by a single level. Along with the three 2-bit leg levels, the block outputs the three line-to-line levels as small signed numbers in units of half the DC bus. Each of these takes one of five values from -2 to +2. A one-cycle strobe marks every step.

Gate timing and dead time are left to the per-leg controllers downstream. For a 50 Hz output, `step_len` is set to one twelfth of the 20 ms period, counted in clock cycles.

Top module: `stair3_seq`

## Requirements
- R1: While reset is held, and until the first step after it, the leg levels are a=2, b=0, c=0. The line outputs are (+2, 0, -2) and `step_pulse` is 0.
- R2: Level encoding is 0 = low, 1 = mid, 2 = high. The value 3 never appears. Listed as a,b,c, the steps visit 200, 210, 220, 120, 020, 021, 022, 012, 002, 102, 202, 201 in that order.
- R3: The step after 201 returns to 200, so the ring repeats every twelve steps.
- R4: While `run_en` is high, a step occurs every `step_len` clock cycles. The first step comes `step_len` cycles after enable rises from a fresh count. Between steps the outputs hold.
- R5: `step_pulse` is high for exactly the one cycle in which the outputs take the new step's values, and low at all other times.
- R6: Each line output equals a level difference (ab = a-b, bc = b-c, ca = c-a) as 3-bit two's complement in [-2, +2]. All three change in the same cycle as the levels.
- R7: At each step exactly one leg changes, and it changes by exactly one level.
- R8: While `run_en` is low, the outputs hold, no strobe is produced and the step count is held. After re-enable, the pending step completes once the remaining cycles have elapsed.
- R9: A `step_len` of 0 behaves like 1, giving one step per enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Advances the step timer when high; freezes everything when low |
| step_len | input | CNT_W | Clock cycles per step (0 treated as 1) |
| lvl_a | output | 2 | Level command, leg a |
| lvl_b | output | 2 | Level command, leg b |
| lvl_c | output | 2 | Level command, leg c |
| line_ab | output | 3 | Signed a-b level in half-bus units |
| line_bc | output | 3 | Signed b-c level in half-bus units |
| line_ca | output | 3 | Signed c-a level in half-bus units |
| step_pulse | output | 1 | One-cycle strobe on each step |

## Verification
A corrupted ring index shows up at the strobe that follows it, as a triple out of order or as a jump in which two legs move, or one leg moves by two levels. Either shows at the ports within one step. A broken line calculation shows as three line values that do not sum to zero, or that disagree with the level differences, in the same cycle as the levels. A timer fault shows as a strobe arriving one or more cycles off the expected count, or a strobe while disabled. Walking the full ring twice at several step lengths therefore exposes each of these faults within one period.

// File: rtl/stair_pkg.sv
package stair_pkg;
  typedef logic [1:0]        lvl_t;
  typedef logic signed [2:0] line_t;

  typedef struct packed {
    lvl_t a;
    lvl_t b;
    lvl_t c;
  } triple_t;

  localparam int RING_LEN = 12;
  localparam int IDX_W    = $clog2(RING_LEN);

  function automatic triple_t ring_entry(input logic [IDX_W-1:0] idx);
    triple_t t;
    case (idx)
      4'd0:    t = '{2'd2, 2'd0, 2'd0};
      4'd1:    t = '{2'd2, 2'd1, 2'd0};
      4'd2:    t = '{2'd2, 2'd2, 2'd0};
      4'd3:    t = '{2'd1, 2'd2, 2'd0};
      4'd4:    t = '{2'd0, 2'd2, 2'd0};
      4'd5:    t = '{2'd0, 2'd2, 2'd1};
      4'd6:    t = '{2'd0, 2'd2, 2'd2};
      4'd7:    t = '{2'd0, 2'd1, 2'd2};
      4'd8:    t = '{2'd0, 2'd0, 2'd2};
      4'd9:    t = '{2'd1, 2'd0, 2'd2};
      4'd10:   t = '{2'd2, 2'd0, 2'd2};
      4'd11:   t = '{2'd2, 2'd0, 2'd1};
      default: t = '{2'd2, 2'd0, 2'd0};
    endcase
    return t;
  endfunction

  function automatic int lvl_dist(input lvl_t x, input lvl_t y);
    return (x > y) ? int'(x) - int'(y) : int'(y) - int'(x);
  endfunction
endpackage

// File: rtl/stair_step_timer.sv
module stair_step_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] step_len,
  output logic             adv
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last  = (step_len == '0) ? '0 : step_len - 1'b1;
    adv   = run_en && (cnt_q >= last);
    cnt_d = cnt_q;
    if (run_en) cnt_d = adv ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: a disabled timer holds its count
  assert_hold_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(cnt_q));
endmodule

// File: rtl/stair_ring.sv
module stair_ring
  import stair_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adv,
  output triple_t next_trip
);
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (adv) idx_d = (idx_q == IDX_W'(RING_LEN - 1)) ? '0 : idx_q + 1'b1;
    next_trip = ring_entry(idx_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // R3: the index stays inside the ring
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(RING_LEN));
endmodule

// File: rtl/stair_line_calc.sv
module stair_line_calc
  import stair_pkg::*;
(
  input  triple_t trip,
  output line_t   ab,
  output line_t   bc,
  output line_t   ca
);
  always_comb begin
    ab = line_t'({1'b0, trip.a} - {1'b0, trip.b});
    bc = line_t'({1'b0, trip.b} - {1'b0, trip.c});
    ca = line_t'({1'b0, trip.c} - {1'b0, trip.a});
  end
endmodule

// File: rtl/stair3_seq.sv
module stair3_seq
  import stair_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] step_len,
  output logic [1:0]       lvl_a,
  output logic [1:0]       lvl_b,
  output logic [1:0]       lvl_c,
  output logic [2:0]       line_ab,
  output logic [2:0]       line_bc,
  output logic [2:0]       line_ca,
  output logic             step_pulse
);
  logic    rs_meta, rs_n;
  logic    adv;
  triple_t next_trip, trip_q;
  line_t   nab, nbc, nca, ab_q, bc_q, ca_q;
  logic    pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  stair_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rs_n), .run_en(run_en), .step_len(step_len), .adv(adv)
  );

  stair_ring u_ring (
    .clk(clk), .rst_n(rs_n), .adv(adv), .next_trip(next_trip)
  );

  stair_line_calc u_calc (
    .trip(next_trip), .ab(nab), .bc(nbc), .ca(nca)
  );

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      trip_q  <= '{2'd2, 2'd0, 2'd0};
      ab_q    <= 3'sd2;
      bc_q    <= 3'sd0;
      ca_q    <= -3'sd2;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= adv;
      if (adv) begin
        trip_q <= next_trip;
        ab_q   <= nab;
        bc_q   <= nbc;
        ca_q   <= nca;
      end
    end
  end

  assign lvl_a      = trip_q.a;
  assign lvl_b      = trip_q.b;
  assign lvl_c      = trip_q.c;
  assign line_ab    = ab_q;
  assign line_bc    = bc_q;
  assign line_ca    = ca_q;
  assign step_pulse = pulse_q;

  // R7: one leg moves, by one level, at each step
  assert_single_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> (lvl_dist(lvl_a, $past(lvl_a)) + lvl_dist(lvl_b, $past(lvl_b))
                    + lvl_dist(lvl_c, $past(lvl_c))) == 1);
  // R8: disabled means no strobe next cycle and frozen outputs
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !step_pulse && $stable({lvl_a, lvl_b, lvl_c, line_ab, line_bc, line_ca}));
  // R6: line levels always sum to zero and stay in range
  assert_line_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_t'(line_ab + line_bc + line_ca) == 3'sd0) && ($signed(line_ab) >= -3'sd2));
  // R2: level code 3 never driven
  assert_no_code3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_a != 2'd3 && lvl_b != 2'd3 && lvl_c != 2'd3);
  // R5: outputs only change together with the strobe
  assert_change_with_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step_pulse |-> $stable({lvl_a, lvl_b, lvl_c}));
endmodule

// File: tb/stair3_seq_bench.sv
module stair3_seq_bench;
  localparam int CW = 24;
  localparam int VEC [12][6] = '{
    '{2,0,0,  2, 0,-2}, '{2,1,0,  1, 1,-2}, '{2,2,0,  0, 2,-2},
    '{1,2,0, -1, 2,-1}, '{0,2,0, -2, 2, 0}, '{0,2,1, -2, 1, 1},
    '{0,2,2, -2, 0, 2}, '{0,1,2, -1,-1, 2}, '{0,0,2,  0,-2, 2},
    '{1,0,2,  1,-2, 1}, '{2,0,2,  2,-2, 0}, '{2,0,1,  2,-1,-1}};

  logic clk = 1'b0;
  logic rst_n, run_en;
  logic [CW-1:0] step_len;
  logic [1:0] lvl_a, lvl_b, lvl_c;
  logic [2:0] line_ab, line_bc, line_ca;
  logic step_pulse;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  stair3_seq #(.CNT_W(CW)) u_stair3_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .step_len(step_len),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c),
    .line_ab(line_ab), .line_bc(line_bc), .line_ca(line_ca),
    .step_pulse(step_pulse));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int i, input int pulse);
    chk({req, " lvl_a"}, int'(lvl_a), VEC[i][0]);
    chk({req, " lvl_b"}, int'(lvl_b), VEC[i][1]);
    chk({req, " lvl_c"}, int'(lvl_c), VEC[i][2]);
    chk({req, " line_ab R6"}, int'($signed(line_ab)), VEC[i][3]);
    chk({req, " line_bc R6"}, int'($signed(line_bc)), VEC[i][4]);
    chk({req, " line_ca R6"}, int'($signed(line_ca)), VEC[i][5]);
    chk({req, " strobe R5"}, int'(step_pulse), pulse);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pos;
    rst_n = 1'b0; run_en = 1'b0; step_len = CW'(5);
    repeat (3) @(negedge clk);
    chk_state("R1 in reset", 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_state("R1 after release", 0, 0);

    // R2 R3 R4: two laps through the table with step_len 5
    run_en = 1'b1;
    pos = 0;
    for (int k = 1; k <= 24; k++) begin
      repeat (4) @(negedge clk);
      chk_state("R4 hold between steps", pos, 0);
      @(negedge clk);
      pos = k % 12;
      chk_state((k > 12) ? "R3 wrap lap" : "R2 order", pos, 1);
    end

    // R8: freeze mid-count
    repeat (2) @(negedge clk);
    run_en = 1'b0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      chk_state("R8 frozen", pos, 0);
    end
    run_en = 1'b1;
    repeat (2) @(negedge clk);
    chk_state("R8 resume hold", pos, 0);
    @(negedge clk);
    pos = (pos + 1) % 12;
    chk_state("R8 resume completes step", pos, 1);

    // R9: step_len 0 steps every enabled cycle
    step_len = '0;
    for (int j = 0; j < 14; j++) begin
      @(negedge clk);
      pos = (pos + 1) % 12;
      chk_state("R9 zero length", pos, 1);
    end

    // R4: step_len 1 also steps every cycle
    step_len = CW'(1);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      pos = (pos + 1) % 12;
      chk_state("R4 length one", pos, 1);
    end

    // R1: reset in mid-run returns to the first entry
    rst_n = 1'b0; run_en = 1'b0;
    @(negedge clk);
    chk_state("R1 mid-run reset", 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step_len = CW'(3); run_en = 1'b1;
    repeat (2) @(negedge clk);
    chk_state("R4 first step pending", 0, 0);
    @(negedge clk);
    chk_state("R4 first step at count", 1, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule